// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block holds the current time and date as seven packed BCD registers: second, minute, hour in 24-hour form, day of week, day of month, month and a two-digit year. A one-cycle strobe arriving once per second from an external prescaler advances the second. Any rollover ripples upward through the fields in that same cycle, as far as the year. The block picks the length of each month by itself, and gives February 29 days whenever the two-digit year is a multiple of four.

A host sets a single field through a synchronous load port. It raises a freeze input while it reads or writes a consistent snapshot. A strobe that arrives during a freeze or a load is held as one pending advance and is applied as soon as the block is free again, so no second is lost. Bus decoding, oscillator trimming and supply monitoring are handled elsewhere.

Top module: `bcd_calendar`

## Requirements
- R1: A synchronous reset sets the fields to second 00, minute 00, hour 00, day of week 1, day of month 01, month 01 and year 00.
- R2: Each accepted strobe advances the second by exactly one in BCD. The second and minute wrap from 59 to 00 and carry into the next field. With no strobe, no field changes.
- R3: The hour wraps from 23 to 00 and carries into both the day of month and the day of week. The day of week runs 1 to 7 and then back to 1.
- R4: The day of month returns to 01 and the month advances after day 30 in months 04, 06, 09 and 11, and after day 31 in months 01, 03, 05, 07, 08, 10 and 12.
- R5: February ends after day 29 when the BCD year is divisible by four (00, 04, … 96), and after day 28 otherwise. No century exception applies.
- R6: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R7: While freeze is high, no field changes. Any number of strobes seen during a freeze, or during a load, count as one pending advance. That advance is applied in the first cycle that has freeze low and no load.
- R8: A load with ld_en high writes ld_val into the field chosen by ld_sel: 0 second, 1 minute, 2 hour, 3 day of week, 4 day of month, 5 month, 6 year. A value of 7 changes nothing. Values are not range-checked. A load wins over an advance in its own cycle, and is allowed while frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_1hz | input | 1 | One-cycle strobe once per second |
| freeze | input | 1 | Holds all fields and defers strobes |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 3 | Field selector for the load |
| ld_val | input | 8 | BCD value to load |
| sec_q | output | 8 | Seconds, BCD |
| min_q | output | 8 | Minutes, BCD |
| hour_q | output | 8 | Hours, BCD, 00–23 |
| wday_q | output | 8 | Day of week, BCD, 1–7 |
| mday_q | output | 8 | Day of month, BCD |
| month_q | output | 8 | Month, BCD |
| year_q | output | 8 | Two-digit year, BCD |

## Verification
Every result shows up on the registered outputs at the rising edge that samples its cause. A strobe, a load or a reset is therefore visible one edge later, and the bench drives on falling edges and compares on the next falling edge. An advance that was deferred by freeze or by a load shows up one edge after the cycle in which freeze and ld_en are both low. The bench first checks that the outputs have not moved, then waits that single edge and checks for exactly one step. The bench keeps an integer calendar model. It compares after every strobe through a full hour from reset, and across the end of every month for years 00–04, 12, 96, 98 and 99.

// File: rtl/bcd_calendar.sv
module bcd_calendar (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_1hz,
  input  logic       freeze,
  input  logic       ld_en,
  input  logic [2:0] ld_sel,
  input  logic [7:0] ld_val,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic [7:0] wday_q,
  output logic [7:0] mday_q,
  output logic [7:0] month_q,
  output logic [7:0] year_q
);
  localparam logic [7:0] MAX_MS    = 8'h59;
  localparam logic [7:0] MAX_HOUR  = 8'h23;
  localparam logic [7:0] MAX_WDAY  = 8'h07;
  localparam logic [7:0] MAX_MONTH = 8'h12;
  localparam logic [7:0] MAX_YEAR  = 8'h99;
  localparam logic [7:0] ONE       = 8'h01;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = v + 8'd1;
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] m, input logic [7:0] y);
    logic leap;
    leap = y[4] ? (y[3:0] == 4'd2 || y[3:0] == 4'd6)
                : (y[3:0] == 4'd0 || y[3:0] == 4'd4 || y[3:0] == 4'd8);
    case (m)
      8'h02:                      month_end = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_end = 8'h30;
      default:                    month_end = 8'h31;
    endcase
  endfunction

  logic pend;
  logic step;
  logic c_min, c_hour, c_day, c_month, c_year;

  assign step    = !freeze && !ld_en && (tick_1hz || pend);
  assign c_min   = step && sec_q == MAX_MS;
  assign c_hour  = c_min && min_q == MAX_MS;
  assign c_day   = c_hour && hour_q == MAX_HOUR;
  assign c_month = c_day && mday_q == month_end(month_q, year_q);
  assign c_year  = c_month && month_q == MAX_MONTH;

  always_ff @(posedge clk) begin
    if (rst)           pend <= 1'b0;
    else if (step)     pend <= 1'b0;
    else if (tick_1hz) pend <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q   <= 8'h00;
      min_q   <= 8'h00;
      hour_q  <= 8'h00;
      wday_q  <= ONE;
      mday_q  <= ONE;
      month_q <= ONE;
      year_q  <= 8'h00;
    end else if (ld_en) begin
      case (ld_sel)
        3'd0: sec_q   <= ld_val;
        3'd1: min_q   <= ld_val;
        3'd2: hour_q  <= ld_val;
        3'd3: wday_q  <= ld_val;
        3'd4: mday_q  <= ld_val;
        3'd5: month_q <= ld_val;
        3'd6: year_q  <= ld_val;
        default: ;
      endcase
    end else if (step) begin
      sec_q <= (sec_q == MAX_MS) ? 8'h00 : bcd_inc(sec_q);
      if (c_min)   min_q   <= (min_q == MAX_MS) ? 8'h00 : bcd_inc(min_q);
      if (c_hour)  hour_q  <= (hour_q == MAX_HOUR) ? 8'h00 : bcd_inc(hour_q);
      if (c_day) begin
        wday_q <= (wday_q == MAX_WDAY) ? ONE : bcd_inc(wday_q);
        mday_q <= c_month ? ONE : bcd_inc(mday_q);
      end
      if (c_month) month_q <= c_year ? ONE : bcd_inc(month_q);
      if (c_year)  year_q  <= (year_q == MAX_YEAR) ? 8'h00 : bcd_inc(year_q);
    end
  end
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_1hz,
  input logic       freeze,
  input logic       ld_en,
  input logic [2:0] ld_sel,
  input logic [7:0] ld_val,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] hour_q,
  input logic [7:0] wday_q,
  input logic [7:0] mday_q,
  input logic [7:0] month_q,
  input logic [7:0] year_q
);
  logic live;
  assign live = tick_1hz && !freeze && !ld_en;

  a_r1_reset_values: assert property (@(posedge clk)
    rst |=> (sec_q == 8'h00 && min_q == 8'h00 && hour_q == 8'h00 && wday_q == 8'h01 &&
             mday_q == 8'h01 && month_q == 8'h01 && year_q == 8'h00));

  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    (live && sec_q == 8'h59) |=> sec_q == 8'h00);

  a_r2_min_hold: assert property (@(posedge clk) disable iff (rst)
    (live && sec_q != 8'h59) |=> $stable(min_q));

  a_r3_hour_wrap: assert property (@(posedge clk) disable iff (rst)
    (live && sec_q == 8'h59 && min_q == 8'h59 && hour_q == 8'h23) |=> hour_q == 8'h00);

  a_r6_year_wrap: assert property (@(posedge clk) disable iff (rst)
    (live && sec_q == 8'h59 && min_q == 8'h59 && hour_q == 8'h23 && mday_q == 8'h31 &&
     month_q == 8'h12 && year_q == 8'h99) |=> (year_q == 8'h00 && month_q == 8'h01));

  a_r7_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    (freeze && !ld_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) &&
      $stable(wday_q) && $stable(mday_q) && $stable(month_q) && $stable(year_q)));

  a_r8_load_sec: assert property (@(posedge clk) disable iff (rst)
    (ld_en && ld_sel == 3'd0) |=> sec_q == $past(ld_val));

  a_r8_load_year: assert property (@(posedge clk) disable iff (rst)
    (ld_en && ld_sel == 3'd6) |=> (year_q == $past(ld_val) && $stable(sec_q)));
endmodule

bind bcd_calendar bcd_calendar_chk chk_i (.*);

// File: tb/bcd_calendar_tb_top.sv
module bcd_calendar_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_1hz = 1'b0, freeze = 1'b0, ld_en = 1'b0;
  logic [2:0] ld_sel = 3'd0;
  logic [7:0] ld_val = 8'd0;
  logic [7:0] sec_q, min_q, hour_q, wday_q, mday_q, month_q, year_q;

  always #4 clk = ~clk;

  bcd_calendar dut_i (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int from_bcd(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction
  function automatic int dim(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0;
          m_dow = (m_dow == 7) ? 1 : m_dow + 1;
          m_date++;
          if (m_date > dim(m_mon, m_yr)) begin
            m_date = 1; m_mon++;
            if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic model_reset();
    m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0;
  endtask

  task automatic check(input string tag);
    logic [55:0] got, exp;
    got = {sec_q, min_q, hour_q, wday_q, mday_q, month_q, year_q};
    exp = {to_bcd(m_sec), to_bcd(m_min), to_bcd(m_hr), to_bcd(m_dow),
           to_bcd(m_date), to_bcd(m_mon), to_bcd(m_yr)};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick_1hz = 1'b1;
    @(negedge clk) tick_1hz = 1'b0;
  endtask

  task automatic load(input logic [2:0] sel, input int v);
    @(negedge clk) begin ld_en = 1'b1; ld_sel = sel; ld_val = to_bcd(v); end
    @(negedge clk) ld_en = 1'b0;
    case (sel)
      3'd0: m_sec = v;  3'd1: m_min = v;  3'd2: m_hr = v;  3'd3: m_dow = v;
      3'd4: m_date = v; 3'd5: m_mon = v;  3'd6: m_yr = v;  default: ;
    endcase
  endtask

  task automatic set_all(input int yr, input int mon, input int date, input int hr,
                         input int mn, input int sc, input int dow);
    load(3'd6, yr); load(3'd5, mon); load(3'd4, date); load(3'd2, hr);
    load(3'd1, mn); load(3'd0, sc); load(3'd3, dow);
  endtask

  function automatic int pick_year(input int i);
    case (i)
      0: return 0;  1: return 1;  2: return 2;  3: return 3;  4: return 4;
      5: return 12; 6: return 96; 7: return 98; default: return 99;
    endcase
  endfunction

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset");

    for (int i = 0; i < 3700; i++) begin
      do_tick(); model_step(); check("R2 second/minute sweep");
    end
    @(negedge clk); @(negedge clk); check("R2 idle no change");

    set_all(0, 1, 1, 23, 59, 0, 7);
    for (int i = 0; i < 65; i++) begin
      do_tick(); model_step(); check("R3 hour wrap and weekday");
    end

    for (int yi = 0; yi < 9; yi++) begin
      for (int mon = 1; mon <= 12; mon++) begin
        int yr;
        string tag;
        yr = pick_year(yi);
        tag = (mon == 2) ? "R5 february" : (mon == 12) ? "R6 year carry" : "R4 month end";
        set_all(yr, mon, dim(mon, yr), 23, 59, 58, 7);
        for (int k = 0; k < 3; k++) begin
          do_tick(); model_step(); check(tag);
        end
      end
    end

    @(negedge clk) freeze = 1'b1;
    do_tick(); check("R7 frozen no change");
    do_tick(); do_tick(); check("R7 frozen several ticks");
    load(3'd1, 33); check("R8 load while frozen");
    @(negedge clk) freeze = 1'b0;
    model_step();
    @(negedge clk) check("R7 single deferred advance");
    @(negedge clk); check("R7 no further advance");

    load(3'd7, 45); check("R8 select 7 ignored");

    @(negedge clk) begin ld_en = 1'b1; ld_sel = 3'd0; ld_val = 8'h10; tick_1hz = 1'b1; end
    @(negedge clk) begin ld_en = 1'b0; tick_1hz = 1'b0; end
    m_sec = 10;
    check("R8 load wins over tick");
    model_step();
    @(negedge clk) check("R8 deferred tick after load");

    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    model_reset();
    check("R1 reset mid-run");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule